// File: doc/BRIEF.md
# Priority Backlog Counter Bank

This block keeps a bank of pending-work counters, eight per target, for two target classes: individual virtual processors and processor groups. Software reaches each counter over a simple single-cycle memory-mapped bus. The access type and the priority are carried in address bits, so one address per counter and operation is enough. A byte write moves a counter by the written amount. A halfword read returns the count. Depending on the address, the read may also bump the count by one after the value is sampled.

Each target index owns two consecutive pages. The lower page holds the processor counters and the upper page holds the group counters. A processor counter only records whether any work is pending, so it holds 0 or 1. A group counter is a true count that stops at zero and at its maximum value. A sideband increment port lets the delivery path raise a counter by one. A bus access to the same counter in the same cycle takes precedence over it.

Top module: `prio_backlog_bank`

## Requirements
- R1: After reset every counter reads 0 and `busRvalid` is low.
- R2: Address decode works as follows. The target index is `busAddr[ADDR_W-1:PAGE_SHIFT+1]`. Page bit `busAddr[PAGE_SHIFT]` selects the class: 0 for processor, 1 for group. The operation field is `busAddr[11:10]`. The priority is `busAddr[6:4]`. All other address bits have no effect.
- R3: A read (`busValid`=1, `busWrite`=0) sets `busRvalid` high for exactly the next cycle. In that cycle `busRdata` holds the counter value as it was before the read.
- R4: A read whose operation field is 2'b10 or 2'b11 leaves the counter unchanged.
- R5: A read with field 2'b00 raises the counter by one. A read with field 2'b01 lowers it by one. Both return the old value.
- R6: A write with field 2'b00 adds `busWdata`. A write with field 2'b01 subtracts `busWdata`. A write with field 2'b10 or 2'b11 has no effect.
- R7: Any increment of a processor counter leaves it at 1, whatever the amount, including 0. A processor counter never exceeds 1.
- R8: A decrement never takes a counter below zero. Subtracting more than the current value leaves 0.
- R9: A group counter that would pass 16'hFFFF stays at 16'hFFFF.
- R10: A `sideValid` pulse raises the counter selected by `sideTarget`/`sideGroup`/`sidePrio` by one. It is dropped when a bus access addresses the same counter in that cycle. It still applies when the bus addresses a different counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = byte write, 0 = halfword read |
| busAddr | input | ADDR_W | Byte address: index, page, operation, priority |
| busWdata | input | 8 | Write amount |
| busRdata | output | 16 | Read count, registered |
| busRvalid | output | 1 | Read data valid, one cycle after a read |
| sideValid | input | 1 | Sideband increment strobe |
| sideTarget | input | TGT_W | Sideband target index |
| sideGroup | input | 1 | Sideband class: 1 = group |
| sidePrio | input | 3 | Sideband priority |

## Verification
A counter update from a write, a read-modify or a sideband pulse is visible at the clock edge that takes the access. A read issued on the next cycle therefore already sees the new value. Read data and `busRvalid` are due one edge after the read request. The bench drives every access on the falling edge and samples `busRdata` on the following falling edge, half a period after the register loads. Write-then-read pairs thus always compare the value that results from the write.

// File: rtl/backlog_pkg.sv
package backlog_pkg;
  localparam int PRIO_W  = 3;
  localparam int CNT_W   = 16;
  localparam int DELTA_W = 8;

  typedef struct packed {
    logic               doUpdate;
    logic               isDec;
    logic               isRead;
    logic [DELTA_W-1:0] delta;
    logic               sideInc;
  } ctlStrb_t;
endpackage

// File: rtl/backlog_ctrl.sv
module backlog_ctrl
  import backlog_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int TGT_W      = 2,
  parameter int ADDR_W     = PAGE_SHIFT + 1 + TGT_W,
  parameter int SEL_W      = TGT_W + 1 + PRIO_W
) (
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DELTA_W-1:0] busWdata,
  input  logic               sideValid,
  input  logic [TGT_W-1:0]   sideTarget,
  input  logic               sideGroup,
  input  logic [PRIO_W-1:0]  sidePrio,
  output ctlStrb_t           strb,
  output logic [SEL_W-1:0]   busSel,
  output logic [SEL_W-1:0]   sideSel
);
  logic [1:0] opField;

  always_comb begin
    opField  = busAddr[11:10];
    busSel   = {busAddr[ADDR_W-1:PAGE_SHIFT+1], busAddr[PAGE_SHIFT], busAddr[6:4]};
    sideSel  = {sideTarget, sideGroup, sidePrio};
    strb.isRead   = busValid & ~busWrite;
    strb.doUpdate = busValid & ~opField[1];
    strb.isDec    = opField[0];
    strb.delta    = busWrite ? busWdata : DELTA_W'(1);
    strb.sideInc  = sideValid & ~(busValid && (busSel == sideSel));
  end
endmodule

// File: rtl/backlog_dp.sv
module backlog_dp
  import backlog_pkg::*;
#(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrb_t         strb,
  input  logic [SEL_W-1:0] busSel,
  input  logic [SEL_W-1:0] sideSel,
  output logic [CNT_W-1:0] busRdata,
  output logic             busRvalid
);
  localparam int NUM_CNT = 1 << SEL_W;

  logic [CNT_W-1:0] cnt [NUM_CNT];

  function automatic logic [CNT_W-1:0] nextVal(input logic [CNT_W-1:0] cur,
      input logic grp, input logic dec, input logic [DELTA_W-1:0] amt);
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] amtW;
    amtW = CNT_W'(amt);
    sum  = {1'b0, cur} + {1'b0, amtW};
    if (dec)       return (cur > amtW) ? cur - amtW : '0;
    else if (!grp) return CNT_W'(1);
    else           return sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  endfunction

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam bit IS_GRP = ((i >> PRIO_W) % 2) == 1;
    logic busHitMe, sideHitMe;
    assign busHitMe  = strb.doUpdate && (busSel == SEL_W'(i));
    assign sideHitMe = strb.sideInc && (sideSel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)         cnt[i] <= '0;
      else if (busHitMe)  cnt[i] <= nextVal(cnt[i], IS_GRP, strb.isDec, strb.delta);
      else if (sideHitMe) cnt[i] <= nextVal(cnt[i], IS_GRP, 1'b0, DELTA_W'(1));
    end

    AST_PLAIN_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.isRead && !strb.doUpdate && busSel == SEL_W'(i)) |=> $stable(cnt[i])); // R4

    AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (busHitMe && strb.isDec && cnt[i] <= CNT_W'(strb.delta)) |=> (cnt[i] == '0)); // R8

    if (IS_GRP) begin : g_grp
      AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busHitMe && !strb.isDec && cnt[i] == '1) |=> (cnt[i] == '1)); // R9
    end else begin : g_proc
      AST_PROC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[i] <= CNT_W'(1)); // R7
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= strb.isRead;
      if (strb.isRead) busRdata <= cnt[busSel];
    end
  end
endmodule

// File: rtl/prio_backlog_bank.sv
module prio_backlog_bank
  import backlog_pkg::*;
#(
  parameter int NUM_TARGETS = 4,
  parameter int PAGE_SHIFT  = 12,
  localparam int TGT_W      = $clog2(NUM_TARGETS),
  localparam int ADDR_W     = PAGE_SHIFT + 1 + TGT_W,
  localparam int SEL_W      = TGT_W + 1 + PRIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DELTA_W-1:0] busWdata,
  output logic [CNT_W-1:0]   busRdata,
  output logic               busRvalid,
  input  logic               sideValid,
  input  logic [TGT_W-1:0]   sideTarget,
  input  logic               sideGroup,
  input  logic [PRIO_W-1:0]  sidePrio
);
  ctlStrb_t         strb;
  logic [SEL_W-1:0] busSel, sideSel;

  backlog_ctrl #(.PAGE_SHIFT(PAGE_SHIFT), .TGT_W(TGT_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .sideValid(sideValid), .sideTarget(sideTarget), .sideGroup(sideGroup), .sidePrio(sidePrio),
    .strb(strb), .busSel(busSel), .sideSel(sideSel));

  backlog_dp #(.SEL_W(SEL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busSel(busSel), .sideSel(sideSel),
    .busRdata(busRdata), .busRvalid(busRvalid));

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !busWrite) |=> busRvalid); // R3

  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(busValid && !busWrite) |=> !busRvalid); // R3
endmodule

// File: tb/prio_backlog_bank_test.sv
module prio_backlog_bank_test;
  logic        clk = 0, rst_n = 0;
  logic        busValid = 0, busWrite = 0;
  logic [14:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [15:0] busRdata;
  logic        busRvalid;
  logic        sideValid = 0, sideGroup = 0;
  logic [1:0]  sideTarget = '0;
  logic [2:0]  sidePrio = '0;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_backlog_bank uut (.clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .sideValid(sideValid), .sideTarget(sideTarget), .sideGroup(sideGroup), .sidePrio(sidePrio));

  function automatic logic [14:0] mkAddr(int tgt, bit grp, int op, int prio);
    return 15'((tgt << 13) | (int'(grp) << 12) | (op << 10) | (prio << 4));
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d);
    @(negedge clk); busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); busValid = 0; busWrite = 0;
  endtask

  task automatic rd(logic [14:0] a, output logic [15:0] d);
    @(negedge clk); busValid = 1; busWrite = 0; busAddr = a;
    @(negedge clk); busValid = 0; d = busRdata;
    check("R3 rvalid", 16'(busRvalid), 16'h1);
  endtask

  task automatic testReset();
    logic [15:0] v;
    check("R1 rvalid low", 16'(busRvalid), 16'h0);
    for (int t = 0; t < 4; t++) begin
      rd(mkAddr(t, 0, 2, 7), v); check("R1 proc zero", v, 0);
      rd(mkAddr(t, 1, 3, 0), v); check("R1 grp zero", v, 0);
    end
    @(negedge clk); check("R3 rvalid one cycle", 16'(busRvalid), 16'h0);
  endtask

  task automatic testProc();
    logic [15:0] v;
    wr(mkAddr(1, 0, 0, 2), 8'd7);
    rd(mkAddr(1, 0, 0, 2), v); check("R7 inc caps at 1", v, 1);
    rd(mkAddr(1, 0, 3, 2), v); check("R7 load-inc stays 1", v, 1);
    rd(mkAddr(1, 0, 1, 2), v); check("R5 load-dec returns old", v, 1);
    rd(mkAddr(1, 0, 2, 2), v); check("R5 load-dec lowered", v, 0);
    wr(mkAddr(1, 0, 1, 2), 8'd7);
    rd(mkAddr(1, 0, 2, 2), v); check("R8 proc floor", v, 0);
    wr(mkAddr(1, 0, 0, 5), 8'd0);
    rd(mkAddr(1, 0, 2, 5), v); check("R7 zero-amount inc", v, 1);
  endtask

  task automatic testGroup();
    logic [15:0] v;
    wr(mkAddr(2, 1, 1, 2), 8'd9);
    rd(mkAddr(2, 1, 3, 2), v); check("R8 grp floor", v, 0);
    wr(mkAddr(2, 1, 0, 2), 8'd9);
    rd(mkAddr(2, 1, 0, 2), v); check("R6 store-inc", v, 9);
    rd(mkAddr(2, 1, 1, 2), v); check("R5 load-inc result", v, 10);
    rd(mkAddr(2, 1, 2, 2), v); check("R5 load-dec result", v, 9);
    rd(mkAddr(2, 1, 2, 2), v); check("R4 plain read stable", v, 9);
    wr(mkAddr(2, 1, 1, 2), 8'd4);
    rd(mkAddr(2, 1, 2, 2), v); check("R6 store-dec", v, 5);
    wr(mkAddr(2, 1, 2, 2), 8'd3);
    wr(mkAddr(2, 1, 3, 2), 8'd3);
    rd(mkAddr(2, 1, 2, 2), v); check("R6 write op 1x ignored", v, 5);
    wr(mkAddr(2, 1, 1, 2), 8'd6);
    rd(mkAddr(2, 1, 2, 2), v); check("R8 grp over-dec", v, 0);
  endtask

  task automatic testDecode();
    logic [15:0] v;
    wr(mkAddr(3, 1, 0, 6) | 15'h038F, 8'd4);
    rd(mkAddr(3, 1, 2, 6), v); check("R2 noise bits ignored", v, 4);
    rd(mkAddr(3, 0, 2, 6), v); check("R2 proc page separate", v, 0);
    rd(mkAddr(0, 1, 2, 6), v); check("R2 other index separate", v, 0);
    rd(mkAddr(3, 1, 2, 7), v); check("R2 other prio separate", v, 0);
  endtask

  task automatic testSat();
    logic [15:0] v;
    for (int k = 0; k < 258; k++) wr(mkAddr(0, 1, 0, 1), 8'hFF);
    rd(mkAddr(0, 1, 2, 1), v); check("R9 saturate", v, 16'hFFFF);
    rd(mkAddr(0, 1, 0, 1), v); check("R9 load-inc old", v, 16'hFFFF);
    rd(mkAddr(0, 1, 2, 1), v); check("R9 load-inc held", v, 16'hFFFF);
  endtask

  task automatic testSide();
    logic [15:0] v;
    @(negedge clk); sideValid = 1; sideTarget = 2; sideGroup = 1; sidePrio = 3;
    @(negedge clk); @(negedge clk); sideValid = 0;
    rd(mkAddr(2, 1, 2, 3), v); check("R10 sideband twice", v, 2);
    @(negedge clk); sideValid = 1; busValid = 1; busWrite = 0; busAddr = mkAddr(2, 1, 2, 3);
    @(negedge clk); sideValid = 0; busValid = 0;
    check("R10 clash read data", busRdata, 2);
    rd(mkAddr(2, 1, 2, 3), v); check("R10 clash dropped", v, 2);
    @(negedge clk); sideValid = 1; busValid = 1; busWrite = 1; busWdata = 8'd5;
    busAddr = mkAddr(2, 1, 0, 4);
    @(negedge clk); sideValid = 0; busValid = 0; busWrite = 0;
    rd(mkAddr(2, 1, 2, 3), v); check("R10 side with other bus", v, 3);
    rd(mkAddr(2, 1, 2, 4), v); check("R10 bus with side", v, 5);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    testReset();
    testProc();
    testGroup();
    testDecode();
    testSat();
    testSide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule